// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers the four level-sensitive interrupt pins of each of several PCI slots onto four shared interrupt lines. The shared line for a pin is rotated by the slot's device number, which spreads the commonly used first pin of neighbouring slots across different lines. Each shared line is then steered by its own 8-bit route byte to one of sixteen legacy interrupt-controller inputs, or to none at all. A route byte of 16 or more turns its line off. Several lines may name the same output, and that output is then the logical OR of those lines.

Software programs the four route bytes through a small write/read port. The port has an index, write data, a write strobe and read data that always shows the addressed byte. The shared line levels are held in a register that samples the slot pins on every rising clock edge. The route bytes are registers as well. The output vector is decoded combinationally from these two registers. A change on the pins or a route write therefore appears on the outputs right after the edge that captures it, and no earlier merged result is kept anywhere.

Top module: `irq_swz_router`

## Requirements
- R1: After a synchronous active-low reset, every route byte reads 8'h80 and `irq_out` is all zeros.
- R2: Slot `s` has device number `DEV_BASE + s`. Its pin `p` (0..3) is input bit `slot_irq[s*4 + p]` and drives shared line `(p + DEV_BASE + s - 1) mod 4`.
- R3: Each shared line level is the OR of all slot pins that rotate onto it. The held line levels are zero during and right after reset.
- R4: Route byte `i`, addressed by `reg_addr = i`, steers shared line `i`. A value from 0 to 15 selects the output with that index.
- R5: A route byte from 16 to 255 (any of bits 7:4 set) disables its line, so that line drives no output.
- R6: Each output bit `k` is the OR of the levels of all enabled shared lines whose route byte low nibble equals `k`.
- R7: A route byte reads back on `reg_rdata` with all 8 bits exactly as written. A write to one index leaves the other three bytes unchanged.
- R8: `irq_out` reflects the `slot_irq` value and the route bytes captured at the most recent rising edge. This holds even when a pin change and a route write land on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the addressed route byte |
| reg_addr | input | 2 | Route byte index, equal to the shared line number |
| reg_wdata | input | 8 | Route byte write data |
| reg_rdata | output | 8 | Current value of the addressed route byte |
| slot_irq | input | NUM_SLOTS*4 | Slot interrupt levels, bit s*4+p is pin p of slot s |
| irq_out | output | 16 | Interrupt levels toward the legacy controller |

## Verification
The hardest cases to reach from the ports are the ones where the route bytes matter more than the pins. One is the boundary between route value 15 and value 16. Another is several lines merging onto one output. A third is a route rewrite landing on the same edge as a pin change. The bench sweeps every one of the 256 values of one route byte with a single known line active. It walks each slot pin alone under distinct routes to expose the rotation. It drives merged and randomized route sets with a bench-side arithmetic model, and often writes a route and changes pins in the same cycle so that stale merged state would show.

// File: rtl/irq_swz_pkg.sv
// Shared constants, types and helpers for the interrupt swizzle router.
// Assumes four pins per slot, four shared lines and 16 outputs.
package irq_swz_pkg;

    localparam int PINS     = 4;
    localparam int LINES    = 4;
    localparam int NUM_OUTS = 16;
    localparam int ROUTE_W  = 8;
    localparam int SEL_W    = $clog2(NUM_OUTS);
    localparam int ADDR_W   = $clog2(LINES);

    typedef logic [ROUTE_W-1:0] route_t;

    localparam route_t ROUTE_RESET = 8'h80;

    // Shared line reached by pin 'pin' of a device numbered 'dev'.
    function automatic logic [ADDR_W-1:0] swz_line(input int dev, input int pin);
        return ADDR_W'((pin + dev + LINES - 1) % LINES);
    endfunction

    // A route byte is live only when it names an output below NUM_OUTS.
    function automatic logic route_live(input route_t r);
        return (r[ROUTE_W-1:SEL_W] == '0);
    endfunction

endpackage

// File: rtl/irq_swz_fold.sv
// Folds every slot pin onto its rotated shared line and holds the
// resulting line levels in a register. Assumes DEV_BASE >= 0.
module irq_swz_fold
    import irq_swz_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DEV_BASE  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS*PINS-1:0] slot_irq,
    output logic [LINES-1:0]          line_q
);

    logic [LINES-1:0] line_d;

    // OR each pin into the line its slot rotation selects.
    always_comb begin
        line_d = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PINS; p++) begin
                line_d[swz_line(DEV_BASE + s, p)] = line_d[swz_line(DEV_BASE + s, p)]
                                                  | slot_irq[s*PINS + p];
            end
        end
    end

    // Capture the line levels; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    // R3: all pins low means all lines low one edge later.
    p_quiet_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_irq == '0) |=> (line_q == '0));

    // R3: line levels start at zero when reset lifts.
    p_lines_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (line_q == '0));

endmodule

// File: rtl/irq_swz_route_regs.sv
// Holds the four route bytes, one per shared line, with an indexed
// write port and a combinational read of the addressed byte.
module irq_swz_route_regs
    import irq_swz_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  route_t                  wdata,
    output route_t                  rdata,
    output logic [LINES-1:0][ROUTE_W-1:0] routes
);

    route_t route_q [LINES];

    // Reset every byte to disabled; store a write to the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) route_q[i] <= ROUTE_RESET;
        end else if (wr_en) begin
            route_q[addr] <= wdata;
        end
    end

    // Present the addressed byte on the read port.
    always_comb rdata = route_q[addr];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_entry
            assign routes[g] = route_q[g];

            // R7: a written byte holds the full written value.
            p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == ADDR_W'(g)) |=> (route_q[g] == $past(wdata)));

            // R7: bytes not addressed keep their value.
            p_others_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && addr == ADDR_W'(g)) |=> $stable(route_q[g]));

            // R1: each byte comes out of reset disabled.
            p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (route_q[g] == ROUTE_RESET));
        end
    endgenerate

endmodule

// File: rtl/irq_swz_merge.sv
// Steers each shared line to the output its route byte names and ORs
// lines that share an output. Purely combinational.
module irq_swz_merge
    import irq_swz_pkg::*;
(
    input  logic [LINES-1:0]              line_lvl,
    input  logic [LINES-1:0][ROUTE_W-1:0] routes,
    output logic [NUM_OUTS-1:0]           irq_out
);

    // Accumulate live lines onto their selected outputs.
    always_comb begin
        irq_out = '0;
        for (int l = 0; l < LINES; l++) begin
            if (route_live(routes[l])) begin
                irq_out[routes[l][SEL_W-1:0]] = irq_out[routes[l][SEL_W-1:0]] | line_lvl[l];
            end
        end
    end

endmodule

// File: rtl/irq_swz_router.sv
// Top of the interrupt swizzle router: slot pins -> rotated shared lines
// -> programmable route to 16 legacy outputs. Assumes one clock domain.
module irq_swz_router
    import irq_swz_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DEV_BASE  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr_en,
    input  logic [1:0]                reg_addr,
    input  logic [7:0]                reg_wdata,
    output logic [7:0]                reg_rdata,
    input  logic [NUM_SLOTS*4-1:0]    slot_irq,
    output logic [15:0]               irq_out
);

    logic [LINES-1:0]              line_q;
    logic [LINES-1:0][ROUTE_W-1:0] routes;

    irq_swz_fold #(
        .NUM_SLOTS (NUM_SLOTS),
        .DEV_BASE  (DEV_BASE)
    ) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_irq (slot_irq),
        .line_q   (line_q)
    );

    irq_swz_route_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .routes (routes)
    );

    irq_swz_merge u_merge (
        .line_lvl (line_q),
        .routes   (routes),
        .irq_out  (irq_out)
    );

    // R6: with no active shared line no output can be high.
    p_idle_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q == '0) |-> (irq_out == '0));

    // R5: with every route byte at 16 or above all outputs stay low.
    p_all_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((routes[0][7:4] != 4'h0) && (routes[1][7:4] != 4'h0) &&
         (routes[2][7:4] != 4'h0) && (routes[3][7:4] != 4'h0)) |-> (irq_out == '0));

    // R6: outputs can never outnumber the shared lines feeding them.
    p_out_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(irq_out) <= $countones(line_q)));

endmodule

// File: tb/irq_swz_router_bench.sv
module irq_swz_router_bench;

    localparam int NS   = 4;
    localparam int DB   = 1;
    localparam int NPIN = NS * 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [NPIN-1:0] slot_irq = '0;
    logic [15:0]     irq_out;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl_route [4];

    irq_swz_router #(.NUM_SLOTS(NS), .DEV_BASE(DB)) u_irq_swz_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .slot_irq  (slot_irq),
        .irq_out   (irq_out)
    );

    always #2.5 clk = ~clk;

    function automatic int line_of(input int s, input int p);
        return (p + DB + s + 3) % 4;
    endfunction

    function automatic logic [15:0] model(input logic [NPIN-1:0] pins);
        logic [3:0]  lv;
        logic [15:0] o;
        lv = '0;
        o  = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (pins[s*4+p]) lv[line_of(s, p)] = 1'b1;
        for (int l = 0; l < 4; l++)
            if (mdl_route[l] < 8'd16 && lv[l]) o[mdl_route[l][3:0]] = 1'b1;
        return o;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [15:0] exp);
        check(irq_out == exp, tag, irq_out, exp);
    endtask

    // Drives one write; the value is in effect after the returned edge.
    task automatic wr(input int idx, input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_addr  = 2'(idx);
        reg_wdata = v;
        mdl_route[idx] = v;
        step();
        reg_wr_en = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input int idx, input logic [7:0] exp);
        reg_addr = 2'(idx);
        #1;
        check(reg_rdata == exp, tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) mdl_route[i] = 8'h80;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        for (int i = 0; i < 4; i++) chk_rd("R1 reset route", i, 8'h80);
        chk_out("R1 reset outputs", 16'h0000);

        // R5: all inputs high with every route disabled
        slot_irq = '1;
        step();
        chk_out("R5 disabled after reset", 16'h0000);
        slot_irq = '0;
        step();

        // R7: readback of full bytes, independent entries
        wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hFF); wr(3, 8'h00);
        chk_rd("R7 readback 0", 0, 8'hA5);
        chk_rd("R7 readback 1", 1, 8'h3C);
        chk_rd("R7 readback 2", 2, 8'hFF);
        chk_rd("R7 readback 3", 3, 8'h00);
        wr(1, 8'h5A);
        chk_rd("R7 neighbour 0", 0, 8'hA5);
        chk_rd("R7 rewritten 1", 1, 8'h5A);
        chk_rd("R7 neighbour 2", 2, 8'hFF);
        chk_rd("R7 neighbour 3", 3, 8'h00);

        // R2 / R4: each pin alone, line j routed to output 4+j
        for (int j = 0; j < 4; j++) wr(j, 8'(4 + j));
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 4; p++) begin
                slot_irq = '0;
                slot_irq[s*4+p] = 1'b1;
                step();
                chk_out("R2 rotation", 16'(1) << (4 + line_of(s, p)));
            end
        end

        // R4 / R5: sweep every value of route byte 0, one pin on line 0
        for (int j = 1; j < 4; j++) wr(j, 8'h80);
        slot_irq = '0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (line_of(s, p) == 0 && s == 0) slot_irq[s*4+p] = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr(0, 8'(v));
            chk_out(v < 16 ? "R4 route select" : "R5 route disable",
                    v < 16 ? (16'(1) << v) : 16'h0000);
        end

        // R6: lines 0,1 merge on output 3; lines 2,3 merge on output 12
        wr(0, 8'd3); wr(1, 8'd3); wr(2, 8'd12); wr(3, 8'd12);
        for (int pat = 0; pat < 16; pat++) begin
            slot_irq = '0;
            slot_irq[7:4] = 4'(pat);
            step();
            chk_out("R6 merge", model(slot_irq));
        end
        for (int j = 0; j < 4; j++) wr(j, 8'd9);
        for (int pat = 1; pat < 16; pat++) begin
            slot_irq = '0;
            slot_irq[11:8] = 4'(pat);
            step();
            chk_out("R6 all on one", 16'h0200);
        end

        // R3: many slots folded onto the same lines, routes j -> j
        for (int j = 0; j < 4; j++) wr(j, 8'(j));
        for (int i = 0; i < 256; i++) begin
            slot_irq = NPIN'(i * 257 + i * 3);
            step();
            chk_out("R3 line OR", model(slot_irq));
        end

        // R8: reroute with input held, then drop input
        wr(1, 8'h80); wr(2, 8'h80); wr(3, 8'h80);
        slot_irq = '0;
        slot_irq[0] = 1'b1;
        wr(0, 8'd5);
        chk_out("R8 route to 5", 16'h0020);
        wr(0, 8'd6);
        chk_out("R8 reroute no stale", 16'h0040);
        slot_irq = '0;
        step();
        chk_out("R8 input drop", 16'h0000);

        // R8: random routes and inputs changing on the same edge
        for (int i = 0; i < 400; i++) begin
            slot_irq = NPIN'($urandom);
            if ($urandom_range(1, 0) == 1) begin
                int idx;
                idx = int'($urandom_range(3, 0));
                reg_wr_en = 1'b1;
                reg_addr  = 2'(idx);
                reg_wdata = 8'($urandom_range(31, 0));
                mdl_route[idx] = reg_wdata;
            end
            step();
            reg_wr_en = 1'b0;
            chk_out("R8 same edge update", model(slot_irq));
        end

        // R1 / R3: reset during activity
        slot_irq = '1;
        step();
        do_reset();
        slot_irq = '0;
        for (int i = 0; i < 4; i++) chk_rd("R1 mid-run reset route", i, 8'h80);
        chk_out("R1 mid-run reset outputs", 16'h0000);
        wr(0, 8'd2);
        chk_out("R3 cleared lines", 16'h0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule